// File: doc/BRIEF.md
# Matrix Tile Reorder Buffer

This block sits in front of (or behind) a block matrix multiplier and changes the element order of whole matrices. In the tiling direction it takes a matrix that arrives one element per cycle in plain row order or plain column order. It emits the same matrix in tile order. The matrix is cut into tiles of `TILE_H` rows by `TILE_W` columns. Each tile leaves as one contiguous run, read out row by row. Tiles are visited across a tile row before moving down to the next tile row. In the de-tiling direction the block applies the exact inverse mapping: a tiled matrix goes in and a plain row-order or column-order matrix comes out.

Storage is a two-bank memory, each bank holding one full matrix. One matrix can be written while the previous one is read, so a steady stream of matrices passes at one element per cycle. The order of each matrix is set by two mode inputs. Both are sampled together with the first element of that matrix and held for the rest of it. Both streams use a valid/ready handshake, and the output is registered.

Top module: `tile_reorder`

## Requirements
- R1: After reset, `out_valid` and `out_last` are 0 and `in_ready` is 1.
- R2: With `cfg_detile`=0 and `cfg_col_major`=0, input element j is the matrix element (r = j / COLS, c = j % COLS). Output element k is the element at row `tr*TILE_H + ir` and column `tc*TILE_W + ic`. Here t = k / (TILE_H*TILE_W) gives tr = t / (COLS/TILE_W) and tc = t % (COLS/TILE_W). Also w = k % (TILE_H*TILE_W) gives ir = w / TILE_W and ic = w % TILE_W.
- R3: With `cfg_detile`=0 and `cfg_col_major`=1, input element j is (r = j % ROWS, c = j / ROWS). The output uses the tile order of R2, so the matrix is transposed into tiles on the fly.
- R4: With `cfg_detile`=1 and `cfg_col_major`=0, input element j is the element at tile position j in the order of R2. Output element k is (r = k / COLS, c = k % COLS).
- R5: With `cfg_detile`=1 and `cfg_col_major`=1, the input is in the tile order of R2. Output element k is (r = k % ROWS, c = k / ROWS).
- R6: Both mode inputs are sampled on the handshake of the first element of each matrix. Values they take during the remaining elements of that matrix have no effect on its output order.
- R7: `out_last` is 1 together with `out_valid` on exactly the final output element of every matrix, and 0 on all others.
- R8: Up to two complete matrices are held. `in_ready` is 0 while both banks hold unread matrices. While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data` and `out_last` keep their values. No element is lost or duplicated under any pattern of stalls.
- R9: With `out_ready` held at 1 and input offered on every cycle, consecutive matrices leave without a gap: 3 matrices produce 3*ROWS*COLS outputs on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_detile | input | 1 | 0 = tile the matrix, 1 = undo tiling |
| cfg_col_major | input | 1 | 1 = plain side of the matrix is in column order |
| in_valid | input | 1 | Input element valid |
| in_ready | output | 1 | Block can accept an element |
| in_data | input | DATA_W | Input element |
| out_valid | output | 1 | Output element valid |
| out_ready | input | 1 | Downstream accepts the output element |
| out_data | output | DATA_W | Output element |
| out_last | output | 1 | Final element of the current matrix |

## Verification
The assertions assume that `ROWS` and `COLS` are multiples of the tile sides, which is enforced at elaboration, and that the downstream side obeys the handshake. They also assume that reads are only started on a bank that has been completely written. The stimulus keeps to this by producing whole matrices only and by never withdrawing `in_valid` once an element is offered. Mode inputs are scrambled mid-matrix only as a deliberate R6 case. Random stalls on both sides, full-buffer backpressure and a gap-free run cover the bank hand-over in both directions.

// File: rtl/tile_reorder_pkg.sv
package tile_reorder_pkg;

  typedef struct packed {
    logic detile;     // 1: tiled in, plain out
    logic col_major;  // 1: plain side is column order
  } order_mode_t;

endpackage

// File: rtl/tile_reorder_ram.sv
module tile_reorder_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // registered read: data holds while rd_en is low
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/tile_reorder_banks.sv
module tile_reorder_banks
  import tile_reorder_pkg::*;
#(
  parameter int ELEMS  = 96,
  parameter int IDX_W  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_fire,
  input  order_mode_t      in_mode,
  input  logic             rd_done,
  output logic             in_ready,
  output logic             wr_bank,
  output logic [IDX_W-1:0] wr_idx,
  output logic             rd_bank,
  output logic             rd_avail,
  output order_mode_t      rd_mode
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ELEMS - 1);

  logic [1:0]       full_q;
  logic             wb_q, rb_q;
  logic [IDX_W-1:0] idx_q;
  order_mode_t      mode_q [2];
  logic             wr_done;

  assign wr_done  = in_fire && (idx_q == LAST_IDX);
  assign in_ready = !full_q[wb_q];
  assign wr_bank  = wb_q;
  assign wr_idx   = idx_q;
  assign rd_bank  = rb_q;
  assign rd_avail = full_q[rb_q];
  assign rd_mode  = mode_q[rb_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= '0;
      wb_q   <= 1'b0;
      rb_q   <= 1'b0;
      idx_q  <= '0;
    end else begin
      if (in_fire) idx_q <= wr_done ? '0 : idx_q + IDX_W'(1);
      if (wr_done) begin
        full_q[wb_q] <= 1'b1;
        wb_q         <= !wb_q;
      end
      if (rd_done) begin
        full_q[rb_q] <= 1'b0;
        rb_q         <= !rb_q;
      end
    end
  end

  // the order of a matrix is fixed by its first element
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q[0] <= '0;
      mode_q[1] <= '0;
    end else if (in_fire && idx_q == '0) begin
      mode_q[wb_q] <= in_mode;
    end
  end

  a_r8_read_only_full: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> full_q[rb_q]);

  a_r8_write_index_range: assert property (@(posedge clk) disable iff (rst)
    idx_q <= LAST_IDX);

  a_r6_mode_frozen_while_filling: assert property (@(posedge clk) disable iff (rst)
    (idx_q != '0) |=> (mode_q[wb_q] == $past(mode_q[wb_q])) || $past(wr_done));

endmodule

// File: rtl/tile_reorder_seq.sv
module tile_reorder_seq
  import tile_reorder_pkg::*;
#(
  parameter int ROWS   = 8,
  parameter int COLS   = 12,
  parameter int TILE_H = 4,
  parameter int TILE_W = 2,
  parameter int IDX_W  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  order_mode_t      mode,
  output logic [IDX_W-1:0] addr,
  output logic             last
);

  localparam int ELEMS   = ROWS * COLS;
  localparam int TCOLS   = COLS / TILE_W;
  localparam int TROWS   = ROWS / TILE_H;
  localparam int TSIZE   = TILE_H * TILE_W;
  localparam int MAXDIM  = (ROWS > COLS) ? ROWS : COLS;
  localparam int CW      = $clog2(MAXDIM + 1);

  localparam logic [CW-1:0] IC_END = CW'(TILE_W - 1);
  localparam logic [CW-1:0] IR_END = CW'(TILE_H - 1);
  localparam logic [CW-1:0] TC_END = CW'(TCOLS - 1);
  localparam logic [CW-1:0] TR_END = CW'(TROWS - 1);
  localparam logic [CW-1:0] R_END  = CW'(ROWS - 1);
  localparam logic [CW-1:0] C_END  = CW'(COLS - 1);

  // tile-walk counters (tiling direction)
  logic [CW-1:0] ic_q, ir_q, tc_q, tr_q;
  // plain-walk counters (de-tiling direction)
  logic [CW-1:0] fast_q, slow_q;
  logic [CW-1:0] fast_end, slow_end;
  logic          tile_last, plain_last;
  int            row, col, lin;

  assign fast_end   = mode.col_major ? R_END : C_END;
  assign slow_end   = mode.col_major ? C_END : R_END;
  assign tile_last  = (ic_q == IC_END) && (ir_q == IR_END) &&
                      (tc_q == TC_END) && (tr_q == TR_END);
  assign plain_last = (fast_q == fast_end) && (slow_q == slow_end);
  assign last       = mode.detile ? plain_last : tile_last;

  always_comb begin
    if (!mode.detile) begin
      row = int'(tr_q) * TILE_H + int'(ir_q);
      col = int'(tc_q) * TILE_W + int'(ic_q);
      lin = mode.col_major ? (col * ROWS + row) : (row * COLS + col);
    end else begin
      row = mode.col_major ? int'(fast_q) : int'(slow_q);
      col = mode.col_major ? int'(slow_q) : int'(fast_q);
      lin = (row / TILE_H) * (COLS * TILE_H) + (col / TILE_W) * TSIZE +
            (row % TILE_H) * TILE_W + (col % TILE_W);
    end
    addr = IDX_W'(lin);
  end

  always_ff @(posedge clk) begin
    if (rst || (step && last)) begin
      ic_q   <= '0;
      ir_q   <= '0;
      tc_q   <= '0;
      tr_q   <= '0;
      fast_q <= '0;
      slow_q <= '0;
    end else if (step) begin
      if (!mode.detile) begin
        if (ic_q == IC_END) begin
          ic_q <= '0;
          if (ir_q == IR_END) begin
            ir_q <= '0;
            if (tc_q == TC_END) begin
              tc_q <= '0;
              tr_q <= tr_q + CW'(1);
            end else begin
              tc_q <= tc_q + CW'(1);
            end
          end else begin
            ir_q <= ir_q + CW'(1);
          end
        end else begin
          ic_q <= ic_q + CW'(1);
        end
      end else begin
        if (fast_q == fast_end) begin
          fast_q <= '0;
          slow_q <= slow_q + CW'(1);
        end else begin
          fast_q <= fast_q + CW'(1);
        end
      end
    end
  end

  a_r2_addr_in_range: assert property (@(posedge clk) disable iff (rst)
    step |-> (int'(addr) < ELEMS));

endmodule

// File: rtl/tile_reorder.sv
module tile_reorder
  import tile_reorder_pkg::*;
#(
  parameter int ROWS   = 8,
  parameter int COLS   = 12,
  parameter int TILE_H = 4,
  parameter int TILE_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_detile,
  input  logic              cfg_col_major,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last
);

  localparam int ELEMS = ROWS * COLS;
  localparam int IDX_W = (ELEMS > 1) ? $clog2(ELEMS) : 1;
  localparam int RAM_W = IDX_W + 1;

  generate
    if ((TILE_H != 2 && TILE_H != 4) || (TILE_W != 2 && TILE_W != 4))
      $error("tile sides must be 2 or 4");
    if ((ROWS % TILE_H) != 0 || (COLS % TILE_W) != 0)
      $error("matrix sides must be multiples of the tile sides");
  endgenerate

  order_mode_t      in_mode, rd_mode;
  logic             in_fire, advance, rd_issue, rd_done, seq_last;
  logic             wr_bank, rd_bank, rd_avail;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic             valid_q, last_q;

  assign in_mode.detile    = cfg_detile;
  assign in_mode.col_major = cfg_col_major;
  assign in_fire  = in_valid && in_ready;
  assign advance  = !valid_q || out_ready;
  assign rd_issue = advance && rd_avail;
  assign rd_done  = rd_issue && seq_last;

  tile_reorder_banks #(
    .ELEMS (ELEMS),
    .IDX_W (IDX_W)
  ) u_banks (
    .clk      (clk),
    .rst      (rst),
    .in_fire  (in_fire),
    .in_mode  (in_mode),
    .rd_done  (rd_done),
    .in_ready (in_ready),
    .wr_bank  (wr_bank),
    .wr_idx   (wr_idx),
    .rd_bank  (rd_bank),
    .rd_avail (rd_avail),
    .rd_mode  (rd_mode)
  );

  tile_reorder_seq #(
    .ROWS   (ROWS),
    .COLS   (COLS),
    .TILE_H (TILE_H),
    .TILE_W (TILE_W),
    .IDX_W  (IDX_W)
  ) u_seq (
    .clk  (clk),
    .rst  (rst),
    .step (rd_issue),
    .mode (rd_mode),
    .addr (rd_idx),
    .last (seq_last)
  );

  tile_reorder_ram #(
    .DATA_W (DATA_W),
    .ADDR_W (RAM_W)
  ) u_ram (
    .clk     (clk),
    .wr_en   (in_fire),
    .wr_addr ({wr_bank, wr_idx}),
    .wr_data (in_data),
    .rd_en   (rd_issue),
    .rd_addr ({rd_bank, rd_idx}),
    .rd_data (out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (advance) begin
      valid_q <= rd_issue;
      last_q  <= rd_done;
    end
  end

  assign out_valid = valid_q;
  assign out_last  = last_q;

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  a_r7_last_with_valid: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

endmodule

// File: tb/tile_reorder_test.sv
module tile_reorder_test;

  localparam int ROWS   = 8;
  localparam int COLS   = 12;
  localparam int TILE_H = 4;
  localparam int TILE_W = 2;
  localparam int DATA_W = 16;
  localparam int N      = ROWS * COLS;
  localparam int TC     = COLS / TILE_W;
  localparam int TS     = TILE_H * TILE_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_detile = 1'b0, cfg_col_major = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic out_valid, out_ready = 1'b0, out_last;
  logic [DATA_W-1:0] out_data;

  always #2 clk = !clk;  // 250 MHz

  tile_reorder #(
    .ROWS(ROWS), .COLS(COLS), .TILE_H(TILE_H), .TILE_W(TILE_W), .DATA_W(DATA_W)
  ) uut (
    .clk(clk), .rst(rst), .cfg_detile(cfg_detile), .cfg_col_major(cfg_col_major),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [DATA_W-1:0] exp_q[$];
  bit                last_q[$];
  int                tag_q[$];
  int                ready_mode = 0;   // 0 always, 1 random, 2 never
  bit                tput_on = 0;
  int                tput_first = -1, tput_last = -1, tput_cnt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic string tag_name(int t);
    case (t)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      default: return "R6";
    endcase
  endfunction

  // row-major index of the element that sits at tile position k
  function automatic int tile_walk(int k);
    int t, w, r, c;
    t = k / TS;
    w = k % TS;
    r = (t / TC) * TILE_H + w / TILE_W;
    c = (t % TC) * TILE_W + w % TILE_W;
    return r * COLS + c;
  endfunction

  // arrival index whose element must appear at output position k
  function automatic int src_of(int k, bit dt, bit cm);
    int rm, r, c;
    if (!dt) begin
      rm = tile_walk(k);
      r = rm / COLS;
      c = rm % COLS;
      return cm ? (c * ROWS + r) : rm;
    end
    if (cm) begin r = k % ROWS; c = k / ROWS; end
    else    begin r = k / COLS; c = k % COLS; end
    for (int j = 0; j < N; j++)
      if (tile_walk(j) == r * COLS + c) return j;
    return -1;
  endfunction

  task automatic check(bit ok, string req, string what, int got, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // call at posedge + 1
  task automatic send_matrix(bit dt, bit cm, bit glitch, int gap_pct);
    logic [DATA_W-1:0] m [N];
    int tg;
    tg = glitch ? 6 : (dt ? (cm ? 5 : 4) : (cm ? 3 : 2));
    for (int j = 0; j < N; j++) m[j] = DATA_W'($urandom);
    for (int k = 0; k < N; k++) begin
      exp_q.push_back(m[src_of(k, dt, cm)]);
      last_q.push_back(k == N - 1);
      tag_q.push_back(tg);
    end
    for (int j = 0; j < N; j++) begin
      while ($urandom_range(99) < gap_pct) begin
        in_valid = 1'b0;
        @(posedge clk); #1;
      end
      in_valid = 1'b1;
      in_data  = m[j];
      if (j == 0 || !glitch) begin
        cfg_detile = dt; cfg_col_major = cm;
      end else begin
        cfg_detile = 1'($urandom); cfg_col_major = 1'($urandom);
      end
      @(negedge clk);
      while (!in_ready) begin
        @(posedge clk); #1;
        @(negedge clk);
      end
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
  endtask

  // output side: ready driven after the edge, checks made at the falling edge
  initial begin
    bit stalled = 0;
    logic [DATA_W-1:0] held_d = '0;
    bit held_l = 0;
    forever begin
      @(posedge clk); #1;
      case (ready_mode)
        0: out_ready = 1'b1;
        1: out_ready = ($urandom_range(99) < 60);
        default: out_ready = 1'b0;
      endcase
      @(negedge clk);
      if (!rst) begin
        if (stalled) begin
          check(out_valid && out_data == held_d && out_last == held_l,
                "R8", "output not held during stall", int'(out_data), int'(held_d));
        end
        stalled = out_valid && !out_ready;
        held_d  = out_data;
        held_l  = out_last;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(0, "R8", "unexpected extra output", int'(out_data), 0);
          end else begin
            logic [DATA_W-1:0] e;
            bit el;
            int t;
            e = exp_q.pop_front(); el = last_q.pop_front(); t = tag_q.pop_front();
            check(out_data == e, tag_name(t), "element order", int'(out_data), int'(e));
            check(out_last == el, "R7", "last flag", int'(out_last), int'(el));
            if (tput_on) begin
              if (tput_first < 0) tput_first = cyc;
              tput_last = cyc;
              tput_cnt++;
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R9", "watchdog expired", cyc, 0);
    finish_test();
  end

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    void'($urandom(32'd20240517));
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(out_last == 1'b0, "R1", "out_last after reset", int'(out_last), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    @(posedge clk); #1;

    // directed: each order once, no stalls (R2 R3 R4 R5)
    ready_mode = 0;
    send_matrix(0, 0, 0, 0);
    send_matrix(0, 1, 0, 0);
    send_matrix(1, 0, 0, 0);
    send_matrix(1, 1, 0, 0);
    drain();

    // R6: mode inputs scrambled after the first element
    send_matrix(0, 1, 1, 10);
    send_matrix(1, 0, 1, 10);
    drain();

    // R8: both banks full blocks input, output stays valid
    ready_mode = 2;
    send_matrix(0, 0, 0, 0);
    send_matrix(1, 1, 0, 0);
    repeat (3) @(posedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b0, "R8", "in_ready with both banks full", int'(in_ready), 0);
    check(out_valid == 1'b1, "R8", "out_valid with data held", int'(out_valid), 1);
    @(posedge clk); #1;
    in_valid = 1'b0;
    ready_mode = 1;
    drain();

    // random traffic with stalls on both sides
    for (int i = 0; i < 16; i++)
      send_matrix(1'($urandom), 1'($urandom), ($urandom_range(3) == 0), 30);
    drain();

    // R9: gap-free streaming
    ready_mode = 0;
    tput_on = 1;
    send_matrix(0, 0, 0, 0);
    send_matrix(0, 1, 0, 0);
    send_matrix(1, 0, 0, 0);
    drain();
    tput_on = 0;
    check(tput_cnt == 3 * N, "R9", "outputs in streaming run", tput_cnt, 3 * N);
    check(tput_last - tput_first == 3 * N - 1, "R9", "cycles spanned by streaming run",
          tput_last - tput_first, 3 * N - 1);

    finish_test();
  end

endmodule